// File: doc/BRIEF.md
# Life-Cycle Stage Advance Controller

This block tracks a device's life-cycle stage and serves system-call requests that move the device into a final return-for-analysis stage. The stage is decoded from three one-time-programmable fuse bits. These bits live outside the block and are watched every cycle. An internal stage register follows that decode but never moves backward.

A requester starts a call by writing a parameter-block address. The block then fetches six parameter words over a word-read port. It checks the opcode, stage, object size, command identifier and die unique ID, in that order, and stops at the first failure. It then checks an external signature-valid flag. A transition request also needs an I/O-supply-OK flag. If both pass, the block programs the return-stage fuse and posts a 32-bit return code.

Once the device is in the return stage, user boot stays disabled. The only call that can then succeed is an open request that carries the same ID words and a valid signature.

Top module: `lcs_advance_ctrl`

## Requirements
- R1: The stage output (0 NORMAL, 1 SECURE_WITH_DEBUG, 2 SECURE, 3 RETURN) follows the highest blown fuse. Fuse bit k blown means stage k+1, so no fuse blown reads NORMAL. The new value appears one clock after the fuse input changes.
- R2: The stage output never decreases, even if the fuse inputs later read lower. Only reset clears it.
- R3: A request address with bits [1:0] not zero is rejected with error code 0x000002, and no parameter word is read.
- R4: Word 0 bits [31:24] select the call: 0x28 means transition and 0x29 means open. Any other value gives error 0x000003. Bits [23:0] of word 0 are ignored.
- R5: A transition is accepted only in stage 1 or 2, and an open only in stage 3. Otherwise the error code is 0x000001.
- R6: Word 1 must equal 0x14, or the error is 0x000004. Word 2 must equal 0x120028F0, or the error is 0x000005.
- R7: Words 3 and 4 must equal the 32-bit device ID words 0 and 1. Bits [23:0] of word 5 must equal the 24-bit ID word 2, and bits [31:24] of word 5 are ignored. Any mismatch gives 0x000006.
- R8: If the signature-valid input is low after the ID check, the error is 0x000007.
- R9: If a transition finds the supply-OK input low, it fails with 0x000008. No program strobe is issued and the stage does not change.
- R10: The return code is {status[31:28], 4'h0, code[23:0]}. Success gives status 0xA with code 0. Error gives status 0xF with a non-zero code.
- R11: An accepted transition raises a one-cycle program strobe with fuse index 2. The block then waits for program-done before it posts success.
- R12: In stage 3, user-boot-enable is low; in every other stage it is high. A successful open raises the analysis-open output.
- R13: Busy is high from the accept until the return code is posted. A request made while busy is ignored. Done is a one-cycle pulse in the cycle in which busy has dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Data-register write strobe |
| req_addr | input | 32 | Parameter-block byte address |
| rd_en | output | 1 | Parameter word read strobe |
| rd_addr | output | 32 | Parameter word byte address |
| rd_data | input | 32 | Read data, valid in the cycle after rd_en |
| dev_id0 | input | 32 | Device ID word 0 |
| dev_id1 | input | 32 | Device ID word 1 |
| dev_id2 | input | 24 | Device ID word 2 |
| sig_ok | input | 1 | Signature verified by external engine |
| supply_ok | input | 1 | I/O supply at programming level |
| fuse_bits | input | 3 | Current fuse values |
| fuse_prog | output | 1 | Single-cycle program strobe |
| fuse_idx | output | 2 | Index of the fuse to program |
| fuse_done | input | 1 | Programming finished |
| busy | output | 1 | Call in progress |
| done | output | 1 | Return code posted (pulse) |
| ret_code | output | 32 | Return code |
| stage | output | 2 | Current life-cycle stage |
| user_boot_en | output | 1 | User boot permitted |
| analysis_open | output | 1 | Return-stage device opened |

## Verification
The request strobe and the posting of a return code can meet on the same clock edge. At that edge busy is still high, so the new request must be dropped. The bench holds req_valid high with a misaligned address for the whole call and releases it only after it sees done. It then expects the aligned request's code, a done pulse of exactly one cycle, and no second done or busy. The fuse program-done and the stage update also land on one edge, so the bench expects stage 3 in the same cycle as the success code.

// File: rtl/lcs_advance_ctrl.sv
module lcs_advance_ctrl #(
  parameter logic [7:0]  OP_TRANSIT = 8'h28,
  parameter logic [7:0]  OP_OPEN    = 8'h29,
  parameter logic [31:0] OBJ_SIZE   = 32'h0000_0014,
  parameter logic [31:0] CMD_ID     = 32'h1200_28F0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [31:0] req_addr,
  output logic        rd_en,
  output logic [31:0] rd_addr,
  input  logic [31:0] rd_data,
  input  logic [31:0] dev_id0,
  input  logic [31:0] dev_id1,
  input  logic [23:0] dev_id2,
  input  logic        sig_ok,
  input  logic        supply_ok,
  input  logic [2:0]  fuse_bits,
  output logic        fuse_prog,
  output logic [1:0]  fuse_idx,
  input  logic        fuse_done,
  output logic        busy,
  output logic        done,
  output logic [31:0] ret_code,
  output logic [1:0]  stage,
  output logic        user_boot_en,
  output logic        analysis_open
);
  localparam logic [2:0]  LAST_W   = 3'd5;
  localparam logic [1:0]  ST_RET   = 2'd3;
  localparam logic [23:0] E_STAGE  = 24'h1, E_ALIGN = 24'h2, E_OPC = 24'h3,
                          E_SIZE   = 24'h4, E_CMD   = 24'h5, E_ID  = 24'h6,
                          E_SIG    = 24'h7, E_SUPPLY = 24'h8;

  typedef enum logic [2:0] {S_IDLE, S_ALERR, S_RD, S_CHK, S_PROG, S_WAIT} st_t;

  st_t         st_q;
  logic [31:0] base_q;
  logic [2:0]  idx_q;
  logic        open_call_q;
  logic [1:0]  stage_q;
  logic [31:0] ret_q;
  logic        done_q;
  logic        open_q;
  logic [23:0] werr;
  logic [1:0]  fuse_stage;

  assign fuse_stage   = fuse_bits[2] ? 2'd3 : fuse_bits[1] ? 2'd2 : fuse_bits[0] ? 2'd1 : 2'd0;
  assign rd_en        = (st_q == S_RD);
  assign rd_addr      = base_q + {27'd0, idx_q, 2'b00};
  assign fuse_prog    = (st_q == S_PROG);
  assign fuse_idx     = 2'd2;
  assign busy         = (st_q != S_IDLE);
  assign done         = done_q;
  assign ret_code     = ret_q;
  assign stage        = stage_q;
  assign user_boot_en = (stage_q != ST_RET);
  assign analysis_open = open_q;

  always_comb begin
    werr = 24'h0;
    case (idx_q)
      3'd0: begin
        if (rd_data[31:24] == OP_TRANSIT) begin
          if (stage_q != 2'd1 && stage_q != 2'd2) werr = E_STAGE;
        end else if (rd_data[31:24] == OP_OPEN) begin
          if (stage_q != ST_RET) werr = E_STAGE;
        end else werr = E_OPC;
      end
      3'd1: if (rd_data != OBJ_SIZE) werr = E_SIZE;
      3'd2: if (rd_data != CMD_ID) werr = E_CMD;
      3'd3: if (rd_data != dev_id0) werr = E_ID;
      3'd4: if (rd_data != dev_id1) werr = E_ID;
      3'd5: if (rd_data[23:0] != dev_id2) werr = E_ID;
      default: werr = 24'h0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'd0;
    else if (fuse_stage > stage_q) stage_q <= fuse_stage;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; base_q <= '0; idx_q <= '0; open_call_q <= 1'b0;
      ret_q <= '0; done_q <= 1'b0; open_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        S_IDLE: if (req_valid) begin
          base_q <= req_addr;
          idx_q  <= '0;
          st_q   <= (req_addr[1:0] != 2'b00) ? S_ALERR : S_RD;
        end
        S_ALERR: begin
          ret_q <= {4'hF, 4'h0, E_ALIGN}; done_q <= 1'b1; st_q <= S_IDLE;
        end
        S_RD: st_q <= S_CHK;
        S_CHK: begin
          if (idx_q == 3'd0) open_call_q <= (rd_data[31:24] == OP_OPEN);
          if (werr != 24'h0) begin
            ret_q <= {4'hF, 4'h0, werr}; done_q <= 1'b1; st_q <= S_IDLE;
          end else if (idx_q != LAST_W) begin
            idx_q <= idx_q + 3'd1; st_q <= S_RD;
          end else if (!sig_ok) begin
            ret_q <= {4'hF, 4'h0, E_SIG}; done_q <= 1'b1; st_q <= S_IDLE;
          end else if (open_call_q) begin
            ret_q <= {4'hA, 28'h0}; done_q <= 1'b1; open_q <= 1'b1; st_q <= S_IDLE;
          end else if (!supply_ok) begin
            ret_q <= {4'hF, 4'h0, E_SUPPLY}; done_q <= 1'b1; st_q <= S_IDLE;
          end else st_q <= S_PROG;
        end
        S_PROG: st_q <= S_WAIT;
        S_WAIT: if (fuse_done) begin
          ret_q <= {4'hA, 28'h0}; done_q <= 1'b1; st_q <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  a_r2_stage_forward: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> stage_q >= $past(stage_q));
  a_r9_prog_needs_supply: assert property (@(posedge clk) disable iff (!rst_n)
    fuse_prog |-> $past(supply_ok));
  a_r11_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    fuse_prog |=> !fuse_prog);
  a_r13_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r13_busy_from_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid));
  a_r10_code_shape: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((ret_code[31:28] == 4'hA && ret_code[27:0] == 28'h0) ||
              (ret_code[31:24] == 8'hF0 && ret_code[23:0] != 24'h0)));
  a_r12_open_only_in_return: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(analysis_open) |-> stage == ST_RET);
endmodule

// File: tb/test_lcs_advance_ctrl.sv
module test_lcs_advance_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic rd_en;
  logic [31:0] rd_addr;
  logic [31:0] rd_data = '0;
  logic [31:0] dev_id0 = 32'h118C_84F4, dev_id1 = 32'h01AF_2C10;
  logic [23:0] dev_id2 = 24'h7A_0415;
  logic sig_ok = 1'b1, supply_ok = 1'b1;
  logic [2:0] fuse_bits = '0;
  logic fuse_prog;
  logic [1:0] fuse_idx;
  logic fuse_done = 1'b0;
  logic busy, done;
  logic [31:0] ret_code;
  logic [1:0] stage;
  logic user_boot_en, analysis_open;

  int n_chk = 0, n_bad = 0, n_strobe = 0;
  logic [31:0] mem [0:63];

  always #5 clk = ~clk;

  lcs_advance_ctrl i_lcs_advance_ctrl (.*);

  initial begin : fuse_model
    int pend = 0;
    forever begin
      @(negedge clk);
      fuse_done = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin fuse_done = 1'b1; fuse_bits[2] = 1'b1; end
      end
      if (fuse_prog) begin
        pend = 3; n_strobe++;
        if (fuse_idx != 2'd2) begin n_bad++; $display("FAIL R11 fuse_idx act=%0d exp=2", fuse_idx); end
      end
      if (rd_en) rd_data = mem[rd_addr[7:2]];
    end
  end

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin n_bad++; $display("FAIL %s act=%h exp=%h", req, act, exp); end
  endtask

  function automatic logic [1:0] dec(input logic [2:0] f);
    return f[2] ? 2'd3 : f[1] ? 2'd2 : f[0] ? 2'd1 : 2'd0;
  endfunction

  function automatic logic [31:0] exp_code(input logic [1:0] st, input logic [31:0] a,
      input logic [31:0] w0, w1, w2, w3, w4, w5, input bit sg, input bit sp);
    logic [23:0] e;
    e = 0;
    if (a[1:0] != 0) e = 2;
    else if (w0[31:24] == 8'h28) begin if (st != 1 && st != 2) e = 1; end
    else if (w0[31:24] == 8'h29) begin if (st != 3) e = 1; end
    else e = 3;
    if (e == 0 && w1 != 32'h14) e = 4;
    if (e == 0 && w2 != 32'h120028F0) e = 5;
    if (e == 0 && (w3 != dev_id0 || w4 != dev_id1 || w5[23:0] != dev_id2)) e = 6;
    if (e == 0 && !sg) e = 7;
    if (e == 0 && w0[31:24] == 8'h28 && !sp) e = 8;
    return (e == 0) ? {4'hA, 28'h0} : {8'hF0, e};
  endfunction

  task automatic do_reset(input logic [2:0] f);
    fuse_bits = f; rst_n = 1'b0; req_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic put(input logic [31:0] a, input logic [31:0] w0, w1, w2, w3, w4, w5);
    mem[a[7:2]] = w0; mem[a[7:2]+1] = w1; mem[a[7:2]+2] = w2;
    mem[a[7:2]+3] = w3; mem[a[7:2]+4] = w4; mem[a[7:2]+5] = w5;
  endtask

  task automatic call(input logic [31:0] a, input bit hold, output logic [31:0] rc);
    int t = 0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    if (hold) req_addr = 32'h0000_0002; else req_valid = 1'b0;
    while (!done && t < 300) begin
      chk(busy == 1'b1, "R13 busy during call", {31'd0, busy}, 32'd1);
      @(negedge clk); t++;
    end
    req_valid = 1'b0;
    rc = ret_code;
    chk(busy == 1'b0, "R13 busy low at done", {31'd0, busy}, 32'd0);
    @(negedge clk);
    chk(done == 1'b0, "R13 done single pulse", {31'd0, done}, 32'd0);
  endtask

  initial begin
    logic [31:0] rc, ex, a, w0, w1, w2, w3, w4, w5;
    logic [2:0] f;
    logic [1:0] st0;
    bit sg, sp;
    void'($urandom(32'd5150));
    for (int i = 0; i < 64; i++) mem[i] = '0;

    do_reset(3'b000);
    chk(stage == 0, "R1 reset stage NORMAL", {30'd0, stage}, 0);
    chk(user_boot_en && !busy && !done && !analysis_open, "R12 reset outputs",
        {28'd0, user_boot_en, busy, done, analysis_open}, 32'h8);

    // R2: fuses read lower later, stage holds
    do_reset(3'b011);
    chk(stage == 2, "R1 decode highest fuse", {30'd0, stage}, 2);
    fuse_bits = 3'b000;
    repeat (3) @(negedge clk);
    chk(stage == 2, "R2 stage never falls", {30'd0, stage}, 2);

    // directed: transition then open, with request held across completion (R13)
    do_reset(3'b001);
    put(32'h40, 32'h2812_3456, 32'h14, 32'h120028F0, dev_id0, dev_id1, {8'h99, dev_id2});
    n_strobe = 0;
    call(32'h40, 1'b1, rc);
    chk(rc == 32'hA000_0000, "R11 transition success", rc, 32'hA000_0000);
    chk(stage == 3 && !user_boot_en, "R12 return stage blocks boot", {30'd0, stage}, 3);
    chk(n_strobe == 1, "R11 one strobe", n_strobe, 1);
    repeat (20) @(negedge clk);
    chk(!busy && !done, "R13 held request ignored", {30'd0, busy, done}, 0);
    mem[16] = 32'h2900_0000;
    call(32'h40, 1'b0, rc);
    chk(rc == 32'hA000_0000 && analysis_open, "R12 open success", rc, 32'hA000_0000);
    call(32'h40 | 32'h1, 1'b0, rc);
    chk(rc == 32'hF000_0002, "R3 misaligned", rc, 32'hF000_0002);

    // directed: supply low, no strobe, stage unchanged
    do_reset(3'b010);
    mem[16] = 32'h2800_0000; n_strobe = 0; supply_ok = 1'b0;
    call(32'h40, 1'b0, rc);
    supply_ok = 1'b1;
    chk(rc == 32'hF000_0008, "R9 supply low", rc, 32'hF000_0008);
    chk(stage == 2 && n_strobe == 0, "R9 no program", {30'd0, stage}, 2);

    // random
    for (int it = 0; it < 200; it++) begin
      f = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 2) == 0) f = 3'b001;
      do_reset(f);
      st0 = dec(f);
      a = {24'd0, 6'($urandom_range(0, 58)), 2'b00};
      w0 = {($urandom_range(0, 3) == 0) ? 8'h29 : 8'h28, 24'($urandom)};
      w1 = 32'h14; w2 = 32'h120028F0; w3 = dev_id0; w4 = dev_id1;
      w5 = {8'($urandom), dev_id2};
      case ($urandom_range(0, 9))
        0: w0[31:24] = 8'($urandom);
        1: w1 = w1 ^ (32'd1 << $urandom_range(0, 31));
        2: w2 = w2 ^ (32'd1 << $urandom_range(0, 31));
        3: w3 = w3 ^ (32'd1 << $urandom_range(0, 31));
        4: w4 = w4 ^ (32'd1 << $urandom_range(0, 31));
        5: w5 = w5 ^ (32'd1 << $urandom_range(0, 23));
        6: a[1:0] = 2'($urandom_range(1, 3));
        default: ;
      endcase
      sg = ($urandom_range(0, 4) != 0);
      sp = ($urandom_range(0, 4) != 0);
      put({a[31:2], 2'b00}, w0, w1, w2, w3, w4, w5);
      sig_ok = sg; supply_ok = sp; n_strobe = 0;
      ex = exp_code(st0, a, w0, w1, w2, w3, w4, w5, sg, sp);
      call(a, it[0], rc);
      chk(rc == ex, "R4 R5 R6 R7 R8 R10 return code", rc, ex);
      if (ex[31:28] == 4'hA && w0[31:24] == 8'h28) begin
        chk(stage == 3 && n_strobe == 1, "R11 stage advanced", {30'd0, stage}, 3);
      end else begin
        chk(stage == st0 && n_strobe == 0, "R9 stage unchanged", {30'd0, stage}, {30'd0, st0});
      end
      chk(user_boot_en == (stage != 3), "R12 boot enable", {31'd0, user_boot_en}, {31'd0, stage != 3});
      chk(analysis_open == (ex[31:28] == 4'hA && w0[31:24] == 8'h29), "R12 open flag",
          {31'd0, analysis_open}, 0);
    end
    sig_ok = 1'b1; supply_ok = 1'b1;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule